// File: doc/BRIEF.md
# Table Entry Writer (Flat or Two-Level)

This block stores one 64-bit entry for an index into a table held in system memory. A command processor gives it an index and an entry word. The block finds the entry's address and issues the memory traffic needed to place the entry there. The table is laid out in one of two ways, chosen by a configuration flag. In the flat layout the entry sits at a fixed stride from the table base. In the two-level layout the table base points at an array of 8-byte pointer words. The block fetches one of these pointer words, checks that it is marked present, and takes from it the base of a page that holds the entries.

Configuration is captured when a request is accepted, so software may change it while a request is in flight. Completion is signalled by a single-cycle done pulse. The pulse carries an error flag when a memory access fails, so that the caller can stall its command stream. A pointer word that is not marked present causes the entry to be dropped without any error.

Top module: `tew_table_writer`

## Requirements
- R1: In flat mode (`cfg_indirect_i`=0) exactly one write is issued, to `cfg_base_i + index * 2^cfg_entry_lg2_i`, and no read is issued. `cfg_entry_lg2_i` is the log2 of the entry size in bytes and is legal from 3 to 6.
- R2: In two-level mode exactly one 64-bit read is issued first, to `cfg_base_i + 8 * (index >> (P - 3))`, where 2^P is the page size in bytes.
- R3: The page-size code `cfg_page_code_i` selects P = 12 for code 0, 14 for code 1 and 16 for code 2. Code 3 gives exactly the same result as code 2.
- R4: If bit 63 of the fetched pointer word is 0, no write is issued and the request completes with `err_o`=0.
- R5: If bit 63 is 1, one write is issued to `B + (index mod 2^(P - entry_lg2)) * 2^entry_lg2`. B is pointer bits [51:0] with bits [P-1:0] cleared and not shifted. Bits [62:52] of the pointer word are ignored.
- R6: The memory port is little-endian: bits [8k+7:8k] of a data word belong to byte address `addr + k`. The entry word is presented unmodified on `mem_wdata_o`.
- R7: When `cfg_table_valid_i`=0 at acceptance, no memory access is made and the request completes with `err_o`=0.
- R8: A memory response with `mem_err_i`=1, on either the pointer read or the entry write, ends the request. `done_o` and `err_o` then both pulse high in the next cycle, and no further access is made for that request.
- R9: `req_ready_o` is high only while the block is idle. A request is accepted on a cycle where `req_valid_i` and `req_ready_o` are both high. `mem_req_o`, `mem_we_o` and `mem_addr_o` stay stable until `mem_ack_i`. `done_o` is a single-cycle pulse, issued the cycle after the last memory acknowledge.
- R10: Index, entry and all configuration inputs are sampled at acceptance. Changing them afterwards has no effect on the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_index_i | input | IDX_W | Table index |
| req_entry_i | input | 64 | Entry word to store |
| cfg_base_i | input | AW | Table base address (pointer array base in two-level mode) |
| cfg_indirect_i | input | 1 | 1 = two-level layout, 0 = flat |
| cfg_page_code_i | input | 2 | Page size code |
| cfg_entry_lg2_i | input | 3 | log2 of entry size in bytes |
| cfg_table_valid_i | input | 1 | Table is present |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 64 | Write data, little-endian |
| mem_ack_i | input | 1 | Access complete |
| mem_err_i | input | 1 | Access failed, valid with ack |
| mem_rdata_i | input | 64 | Read data, valid with ack |
| done_o | output | 1 | Request finished, one cycle |
| err_o | output | 1 | Request ended on a memory error, valid with done |

## Verification
The assertions check on every cycle that the memory request is held steady until acknowledged and that done lasts one cycle. They also check that an error response or an absent pointer word leads straight to done with the matching error flag, and that no access starts for an absent table. For two-level writes they check that the write lands inside the page named by the captured pointer word, so the slot offset never carries into the page number. Only the bench's scenarios can show the actual address arithmetic: the pointer slot for each page-size code, code 3 aliasing code 2, the modulo slot for several entry sizes and boundary indices, and the isolation from configuration changed mid-request.

// File: rtl/tew_pkg.sv
package tew_pkg;
  parameter int unsigned PAGE_LG2_C0 = 12;
  parameter int unsigned PAGE_LG2_C1 = 14;
  parameter int unsigned PAGE_LG2_C2 = 16;
  parameter int unsigned PTR_LG2     = 3;   // pointer words are 8 bytes
  parameter int unsigned PTR_VLD_BIT = 63;
  parameter int unsigned PTR_ADDR_W  = 52;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_PTR,
    ST_WR,
    ST_FIN
  } tew_state_e;

  function automatic logic [4:0] page_lg2(input logic [1:0] code);
    case (code)
      2'd0:    page_lg2 = 5'(PAGE_LG2_C0);
      2'd1:    page_lg2 = 5'(PAGE_LG2_C1);
      default: page_lg2 = 5'(PAGE_LG2_C2); // code 3 aliases code 2
    endcase
  endfunction
endpackage

// File: rtl/tew_addr_gen.sv
module tew_addr_gen #(
  parameter int unsigned AW    = 52,
  parameter int unsigned IDX_W = 16
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic             indirect_i,
  input  logic [1:0]       page_code_i,
  input  logic [2:0]       entry_lg2_i,
  input  logic [AW-1:0]    ptr_addr_i,
  output logic [AW-1:0]    ptr_slot_addr_o,
  output logic [AW-1:0]    wr_addr_o
);
  import tew_pkg::*;

  logic [4:0]    plg;
  logic [4:0]    slot_lg2;
  logic [AW-1:0] idx_ext;
  logic [AW-1:0] ptr_slot;
  logic [AW-1:0] page_mask;
  logic [AW-1:0] slot_mask;
  logic [AW-1:0] page_base;
  logic [AW-1:0] flat_addr;
  logic [AW-1:0] leaf_addr;

  always_comb begin
    plg       = page_lg2(page_code_i);
    slot_lg2  = plg - {2'b00, entry_lg2_i};
    idx_ext   = AW'(index_i);
    ptr_slot  = idx_ext >> (plg - 5'(PTR_LG2));
    ptr_slot_addr_o = base_i + (ptr_slot << PTR_LG2);
    page_mask = (AW'(1) << plg) - AW'(1);
    slot_mask = (AW'(1) << slot_lg2) - AW'(1);
    page_base = ptr_addr_i & ~page_mask;   // unshifted, low bits dropped
    leaf_addr = page_base + ((idx_ext & slot_mask) << entry_lg2_i);
    flat_addr = base_i + (idx_ext << entry_lg2_i);
    wr_addr_o = indirect_i ? leaf_addr : flat_addr;
  end
endmodule

// File: rtl/tew_ctrl.sv
module tew_ctrl #(
  parameter int unsigned AW    = 52,
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [IDX_W-1:0] req_index_i,
  input  logic [63:0]      req_entry_i,
  input  logic [AW-1:0]    cfg_base_i,
  input  logic             cfg_indirect_i,
  input  logic [1:0]       cfg_page_code_i,
  input  logic [2:0]       cfg_entry_lg2_i,
  input  logic             cfg_table_valid_i,
  output logic [IDX_W-1:0] index_q_o,
  output logic [AW-1:0]    base_q_o,
  output logic             indirect_q_o,
  output logic [1:0]       page_code_q_o,
  output logic [2:0]       entry_lg2_q_o,
  output logic [AW-1:0]    ptr_addr_q_o,
  input  logic [AW-1:0]    ptr_slot_addr_i,
  input  logic [AW-1:0]    wr_addr_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [63:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             done_o,
  output logic             err_o
);
  import tew_pkg::*;

  tew_state_e state_q, state_d;
  logic [63:0] entry_q;
  logic        tv_q;
  logic        err_q, err_d;
  logic        accept;
  logic        ptr_vld;
  logic        unused_rsvd;

  assign accept      = req_valid_i && (state_q == ST_IDLE);
  assign ptr_vld     = mem_rdata_i[PTR_VLD_BIT];
  assign unused_rsvd = ^mem_rdata_i[62:AW];

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        err_d = 1'b0;
        if (!cfg_table_valid_i)  state_d = ST_FIN;
        else if (cfg_indirect_i) state_d = ST_RD_PTR;
        else                     state_d = ST_WR;
      end
      ST_RD_PTR: if (mem_ack_i) begin
        if (mem_err_i) begin
          err_d   = 1'b1;
          state_d = ST_FIN;
        end else if (ptr_vld) begin
          state_d = ST_WR;
        end else begin
          state_d = ST_FIN;
        end
      end
      ST_WR: if (mem_ack_i) begin
        err_d   = mem_err_i;
        state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      err_q         <= 1'b0;
      entry_q       <= '0;
      tv_q          <= 1'b0;
      index_q_o     <= '0;
      base_q_o      <= '0;
      indirect_q_o  <= 1'b0;
      page_code_q_o <= '0;
      entry_lg2_q_o <= 3'd3;
      ptr_addr_q_o  <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (accept) begin
        entry_q       <= req_entry_i;
        tv_q          <= cfg_table_valid_i;
        index_q_o     <= req_index_i;
        base_q_o      <= cfg_base_i;
        indirect_q_o  <= cfg_indirect_i;
        page_code_q_o <= cfg_page_code_i;
        entry_lg2_q_o <= cfg_entry_lg2_i;
      end
      if (state_q == ST_RD_PTR && mem_ack_i && !mem_err_i)
        ptr_addr_q_o <= mem_rdata_i[AW-1:0];
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_RD_PTR) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = (state_q == ST_WR) ? wr_addr_i : ptr_slot_addr_i;
  assign mem_wdata_o = entry_q;
  assign done_o      = (state_q == ST_FIN);
  assign err_o       = done_o && err_q;

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_no_access_absent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> tv_q);
  assert_err_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && mem_err_i) |=> (done_o && err_o && !mem_req_o));
  assert_skip_ptr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i && !mem_err_i && !mem_rdata_i[PTR_VLD_BIT])
      |=> (done_o && !err_o));
endmodule

// File: rtl/tew_table_writer.sv
module tew_table_writer #(
  parameter int unsigned AW    = 52,
  parameter int unsigned IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [IDX_W-1:0] req_index_i,
  input  logic [63:0]      req_entry_i,
  input  logic [AW-1:0]    cfg_base_i,
  input  logic             cfg_indirect_i,
  input  logic [1:0]       cfg_page_code_i,
  input  logic [2:0]       cfg_entry_lg2_i,
  input  logic             cfg_table_valid_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [63:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic             mem_err_i,
  input  logic [63:0]      mem_rdata_i,
  output logic             done_o,
  output logic             err_o
);
  import tew_pkg::*;

  logic [IDX_W-1:0] index_q;
  logic [AW-1:0]    base_q;
  logic             indirect_q;
  logic [1:0]       page_code_q;
  logic [2:0]       entry_lg2_q;
  logic [AW-1:0]    ptr_addr_q;
  logic [AW-1:0]    ptr_slot_addr;
  logic [AW-1:0]    wr_addr;

  tew_addr_gen #(.AW(AW), .IDX_W(IDX_W)) u_addr (
    .base_i          (base_q),
    .index_i         (index_q),
    .indirect_i      (indirect_q),
    .page_code_i     (page_code_q),
    .entry_lg2_i     (entry_lg2_q),
    .ptr_addr_i      (ptr_addr_q),
    .ptr_slot_addr_o (ptr_slot_addr),
    .wr_addr_o       (wr_addr)
  );

  tew_ctrl #(.AW(AW), .IDX_W(IDX_W)) u_ctrl (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .req_valid_i       (req_valid_i),
    .req_ready_o       (req_ready_o),
    .req_index_i       (req_index_i),
    .req_entry_i       (req_entry_i),
    .cfg_base_i        (cfg_base_i),
    .cfg_indirect_i    (cfg_indirect_i),
    .cfg_page_code_i   (cfg_page_code_i),
    .cfg_entry_lg2_i   (cfg_entry_lg2_i),
    .cfg_table_valid_i (cfg_table_valid_i),
    .index_q_o         (index_q),
    .base_q_o          (base_q),
    .indirect_q_o      (indirect_q),
    .page_code_q_o     (page_code_q),
    .entry_lg2_q_o     (entry_lg2_q),
    .ptr_addr_q_o      (ptr_addr_q),
    .ptr_slot_addr_i   (ptr_slot_addr),
    .wr_addr_i         (wr_addr),
    .mem_req_o         (mem_req_o),
    .mem_we_o          (mem_we_o),
    .mem_addr_o        (mem_addr_o),
    .mem_wdata_o       (mem_wdata_o),
    .mem_ack_i         (mem_ack_i),
    .mem_err_i         (mem_err_i),
    .mem_rdata_i       (mem_rdata_i),
    .done_o            (done_o),
    .err_o             (err_o)
  );

  logic [4:0] plg_q;
  assign plg_q = page_lg2(page_code_q);

  // leaf write must stay inside the page named by the pointer word
  assert_leaf_in_page_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && indirect_q) |-> ((mem_addr_o >> plg_q) == (ptr_addr_q >> plg_q)));
endmodule

// File: tb/sim_tew_table_writer.sv
`timescale 1ns/1ps
module sim_tew_table_writer;
  localparam int AW = 52;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [IW-1:0] req_index = '0;
  logic [63:0]   req_entry = '0;
  logic [AW-1:0] cfg_base = '0;
  logic          cfg_ind = 1'b0, cfg_tv = 1'b0;
  logic [1:0]    cfg_code = '0;
  logic [2:0]    cfg_lg2 = 3'd3;
  logic          mem_req, mem_we, done, err;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata;
  logic          ack_q, merr_q;
  logic [63:0]   rd_q;

  tew_table_writer #(.AW(AW), .IDX_W(IW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_index_i(req_index), .req_entry_i(req_entry), .cfg_base_i(cfg_base),
    .cfg_indirect_i(cfg_ind), .cfg_page_code_i(cfg_code), .cfg_entry_lg2_i(cfg_lg2),
    .cfg_table_valid_i(cfg_tv), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(ack_q),
    .mem_err_i(merr_q), .mem_rdata_i(rd_q), .done_o(done), .err_o(err));

  logic [63:0] mem [longint];
  longint err_addr = -1;
  int wr_cnt = 0, rd_cnt = 0;
  longint last_wr_addr = 0, last_rd_addr = 0;
  logic [63:0] last_wdata = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0; merr_q <= 1'b0; rd_q <= '0;
    end else if (mem_req && !ack_q) begin
      longint a;
      a = longint'(mem_addr);
      ack_q <= 1'b1;
      if (a == err_addr) merr_q <= 1'b1;
      else begin
        merr_q <= 1'b0;
        if (mem_we) begin
          mem[a] = mem_wdata; wr_cnt++; last_wr_addr = a; last_wdata = mem_wdata;
        end else begin
          rd_cnt++; last_rd_addr = a;
          rd_q <= mem.exists(a) ? mem[a] : 64'h0;
        end
      end
    end else begin
      ack_q <= 1'b0; merr_q <= 1'b0;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  function automatic int plg(input int code);
    return (code == 0) ? 12 : (code == 1) ? 14 : 16;
  endfunction

  bit op_err;
  task automatic run_op(input longint idx, input logic [63:0] ent, input bit tv, input bit ind,
                        input int code, input int lg2, input longint base);
    int n;
    @(negedge clk);
    req_index = IW'(idx); req_entry = ent; cfg_tv = tv; cfg_ind = ind;
    cfg_code = 2'(code); cfg_lg2 = 3'(lg2); cfg_base = AW'(base); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R10: scramble everything after acceptance
    req_index = ~req_index; req_entry = ~req_entry; cfg_tv = ~cfg_tv; cfg_ind = ~cfg_ind;
    cfg_code = cfg_code + 2'd1; cfg_lg2 = 3'd6; cfg_base = ~cfg_base;
    chk(req_ready == 1'b0, "R9 busy", longint'(req_ready), 0);
    n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R9 done", longint'(done), 1);
    op_err = err;
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse", longint'(done), 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    longint tbase, l2page, exp_wr, exp_rd, idx, per;
    logic [63:0] ent, desc;
    int w0, r0;
    longint idxs[5];
    tbase = 64'h10_0000;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0, "R9 reset",
        {req_ready, mem_req, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    // two-level sweep: page codes 0..3 (R3), entry sizes 8 and 16 bytes
    for (int code = 0; code < 4; code++) begin
      for (int lg2 = 3; lg2 < 5; lg2++) begin
        per = 64'd1 << (plg(code) - lg2);
        idxs[0] = 0; idxs[1] = 1; idxs[2] = per - 1; idxs[3] = per; idxs[4] = 2 * per + 3;
        for (int k = 0; k < 5; k++) begin
          for (int v = 0; v < 2; v++) begin
            idx = idxs[k];
            exp_rd = tbase + 8 * (idx >> (plg(code) - 3));
            l2page = 64'h000A_0000_0000 + ((idx >> (plg(code) - 3)) << 16) + 64'h3_0000 * k;
            desc = {1'(v), 11'h5A5, 52'(l2page | ((64'd1 << (plg(code) - 1)) + 7))};
            mem[exp_rd] = desc;
            exp_wr = l2page + ((idx & (per - 1)) << lg2);
            ent = {32'(code * 16 + lg2), 16'(k), 16'(v)} ^ 64'h0102_0304_0506_0708;
            w0 = wr_cnt; r0 = rd_cnt;
            run_op(idx, ent, 1'b1, 1'b1, code, lg2, tbase);
            chk(rd_cnt == r0 + 1, "R2 one read", rd_cnt - r0, 1);
            chk(last_rd_addr == exp_rd, "R2/R3 pointer slot", last_rd_addr, exp_rd);
            chk(op_err == 1'b0, "R4/R5 no error", longint'(op_err), 0);
            if (v == 1) begin
              chk(wr_cnt == w0 + 1, "R5 one write", wr_cnt - w0, 1);
              chk(last_wr_addr == exp_wr, "R5 leaf address", last_wr_addr, exp_wr);
              chk(last_wdata == ent && last_wdata[7:0] == ent[7:0], "R6 entry data", last_wdata, ent);
            end else begin
              chk(wr_cnt == w0, "R4 dropped", wr_cnt - w0, 0);
            end
          end
        end
      end
    end

    // flat sweep (R1)
    for (int lg2 = 3; lg2 < 7; lg2++) begin
      idxs[0] = 0; idxs[1] = 1; idxs[2] = 255; idxs[3] = 16'h1234; idxs[4] = 16'hFFFF;
      for (int k = 0; k < 5; k++) begin
        idx = idxs[k];
        exp_wr = tbase + (idx << lg2);
        ent = 64'hA5A5_0000_0000_0000 | (idx << 8) | lg2;
        w0 = wr_cnt; r0 = rd_cnt;
        run_op(idx, ent, 1'b1, 1'b0, k % 4, lg2, tbase);
        chk(rd_cnt == r0, "R1 no read", rd_cnt - r0, 0);
        chk(wr_cnt == w0 + 1 && last_wr_addr == exp_wr, "R1 flat address", last_wr_addr, exp_wr);
        chk(mem[exp_wr] == ent, "R6 stored word", mem[exp_wr], ent);
      end
    end

    // absent table (R7)
    for (int ind = 0; ind < 2; ind++) begin
      w0 = wr_cnt; r0 = rd_cnt;
      run_op(5, 64'h77, 1'b0, 1'(ind), 0, 3, tbase);
      chk(wr_cnt == w0 && rd_cnt == r0, "R7 no access", (wr_cnt - w0) + (rd_cnt - r0), 0);
      chk(op_err == 1'b0, "R7 no error", longint'(op_err), 0);
    end

    // memory errors (R8)
    mem[tbase] = {1'b1, 11'h0, 52'h0000B_0000_0000};
    err_addr = tbase;
    w0 = wr_cnt; r0 = rd_cnt;
    run_op(3, 64'h1111, 1'b1, 1'b1, 0, 3, tbase);
    chk(op_err == 1'b1, "R8 read error", longint'(op_err), 1);
    chk(wr_cnt == w0, "R8 no write after read error", wr_cnt - w0, 0);
    err_addr = 64'h0000B_0000_0000 + 3 * 8;
    w0 = wr_cnt;
    run_op(3, 64'h2222, 1'b1, 1'b1, 0, 3, tbase);
    chk(op_err == 1'b1, "R8 write error", longint'(op_err), 1);
    chk(wr_cnt == w0 && !mem.exists(err_addr), "R8 write dropped", wr_cnt - w0, 0);
    err_addr = tbase + 8 * 40;
    run_op(40, 64'h3333, 1'b1, 1'b0, 0, 3, tbase);
    chk(op_err == 1'b1, "R8 flat write error", longint'(op_err), 1);
    err_addr = -1;
    run_op(40, 64'h4444, 1'b1, 1'b0, 0, 3, tbase);
    chk(op_err == 1'b0 && mem[tbase + 320] == 64'h4444, "R8 recovery", longint'(op_err), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule